// File: doc/BRIEF.md
# Trigger-Windowed Cyclic Sample Buffer

The block takes a stream of sample sets, each carrying one 18-bit word for each of 16 channels, and keeps the most recent 512 sets in a ring that overwrites its oldest slot on every new set. A trigger pulse arrives with a sub-sample time code. The block reserves a 60-sample window for that trigger which begins 22 samples before the trigger, so part of the window lies in the past and the rest is still being collected.

Pending triggers wait in an eight-entry first-in first-out queue. Once the head trigger's window is fully collected, the block raises a readout request. A downstream consumer grants it when ready. On the grant, the block either streams the window, one channel at a time with each channel oldest first, or drops the trigger as stale if the ring has already overwritten its first sample. A trigger that arrives while the queue is full is dropped and flagged.

Top module: `trig_window_buf`

## Requirements
- R1: On every cycle with `smp_valid` high, the block stores all 16 channel words (channel c in `smp_data[c*18 +: 18]`) in the next ring slot. The ring holds 512 sample sets, and a read of sample n returns the word written for sample n after the ring has wrapped.
- R2: A trigger captures `trig_code` (a value from 0 to 143). That code is presented unchanged on `out_code` with every word of that trigger's window.
- R3: At most 8 triggers are pending. A trigger that arrives while 8 are pending is discarded, and `trig_drop` is high for exactly the cycle after it. An accepted trigger never raises `trig_drop`.
- R4: Pending triggers are served strictly in the order they arrived.
- R5: `rd_req` is high only while the oldest pending trigger's window is complete (the sample count has reached the trigger-time count plus 38) and no words are being streamed. Readout starts only on a cycle where both `rd_req` and `rd_grant` are high. Without a grant, no word is produced.
- R6: A window with the trigger taken at sample count N covers samples N-22 to N+37. It is streamed on consecutive cycles: channel 0 first, up to channel 15, each channel's 60 samples oldest first. `out_chan` gives the channel index, and `out_last` is high on the 60th word of each channel.
- R7: On a grant, a trigger is dropped without any data, and `stale_drop` is high for one cycle, if more than 512 samples have been stored since the window's first sample or if fewer than 22 samples had been stored when the trigger arrived. Its queue entry is then removed.
- R8: A trigger whose window start lies exactly 512 samples behind the current sample count is still streamed with correct data.
- R9: After reset the queue is empty and `rd_req`, `out_valid`, `trig_drop` and `stale_drop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample set is present on `smp_data` |
| smp_data | input | 288 | 16 channel words, channel c at bits c*18 and up |
| trig | input | 1 | Trigger pulse, one cycle |
| trig_code | input | 8 | Sub-sample time code of the trigger, 0 to 143 |
| rd_grant | input | 1 | Consumer accepts the pending readout request |
| rd_req | output | 1 | Oldest trigger's window is ready to be read |
| out_valid | output | 1 | `out_data` carries a window word |
| out_chan | output | 4 | Channel index of the current word |
| out_data | output | 18 | Sample word |
| out_last | output | 1 | Final word of the current channel |
| out_code | output | 8 | Time code of the trigger being streamed |
| trig_drop | output | 1 | A trigger was discarded because the queue was full |
| stale_drop | output | 1 | A granted trigger was discarded because its data had aged out |

## Verification
Four behaviours are checked by assertions on every cycle: the queue never holds more than eight entries and a full-queue trigger always produces a drop flag; a stream starts only two cycles after a grant; a stale drop never coincides with data; and the channel index holds steady through 60 words and then steps by one. The exact word values after the ring wraps, the first-in first-out order across several triggers, the code carried with each window, and the two stale boundaries (too few samples before the trigger, and ages of 512 versus 513) depend on history. Only the bench's scenarios, with a scoreboard model, can show those.

// File: rtl/twb_pkg.sv
package twb_pkg;

   // readout sequencer states
   typedef enum logic {
      RS_IDLE   = 1'b0,
      RS_STREAM = 1'b1
   } rd_state_t;

   // largest legal sub-sample time code
   localparam int unsigned TCODE_MAX = 143;

endpackage

// File: rtl/twb_ring.sv
// Circular sample store: one slot per sample set, all channels side by side.
module twb_ring #(
   parameter  int NCH        = 16,
   parameter  int SW         = 18,
   parameter  int DEPTH      = 512,
   parameter  int LANE_SPLIT = 0,
   localparam int AW         = $clog2(DEPTH),
   localparam int WW         = NCH * SW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [WW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [WW-1:0] rword
);

   generate
      if (LANE_SPLIT != 0) begin : g_lanes
         // one narrow array per channel
         for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [SW-1:0] mem [DEPTH];
            always_ff @(posedge clk) begin
               if (we) mem[waddr] <= wdata[c*SW +: SW];
               rword[c*SW +: SW] <= mem[raddr];
            end
         end
      end else begin : g_wide
         // single wide array, one slot holds a whole sample set
         logic [WW-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
            rword <= mem[raddr];
         end
      end
   endgenerate

endmodule

// File: rtl/twb_tqueue.sv
// First-in first-out queue of pending trigger records.
module twb_tqueue #(
   parameter  int EW = 33,
   parameter  int QD = 8,
   localparam int PW = (QD > 1) ? $clog2(QD) : 1,
   localparam int CW = $clog2(QD + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [EW-1:0] din,
   input  logic          pop,
   output logic [EW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [EW-1:0] slots [QD];
   logic [PW-1:0] rp, wp;
   logic          push_ok, pop_ok;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(QD - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (count == CW'(QD));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = slots[rp];

   always_ff @(posedge clk) begin
      if (push_ok) slots[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp <= step(wp);
         if (pop_ok)  rp <= step(rp);
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

endmodule

// File: rtl/twb_reader.sv
// Readout sequencer: age check on grant, then channel-major window stream.
module twb_reader
   import twb_pkg::*;
#(
   parameter  int NCH   = 16,
   parameter  int WIN   = 60,
   parameter  int DEPTH = 512,
   parameter  int AGEW  = 24,
   parameter  int TCW   = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int IW    = $clog2(WIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            head_valid,
   input  logic            head_hist,
   input  logic [AGEW-1:0] head_start,
   input  logic [TCW-1:0]  head_code,
   input  logic [AGEW-1:0] wr_abs,
   input  logic            rd_grant,
   output logic            rd_req,
   output logic            pop,
   output logic [AW-1:0]   raddr,
   output logic            o_valid,
   output logic [CHW-1:0]  o_ch,
   output logic            o_last,
   output logic [TCW-1:0]  o_code,
   output logic            o_stale
);

   rd_state_t       st;
   logic [IW-1:0]   idx;
   logic [CHW-1:0]  ch;
   logic [AW-1:0]   base;
   logic [TCW-1:0]  code_r;
   logic [AGEW-1:0] age;
   logic            win_done, too_old, take, idx_end, ch_end;

   // samples stored since the window's first sample
   assign age      = wr_abs - head_start;
   assign win_done = (age >= AGEW'(WIN));
   assign too_old  = !head_hist || (age > AGEW'(DEPTH));

   assign rd_req  = (st == RS_IDLE) && !o_valid && head_valid && win_done;
   assign take    = rd_req && rd_grant;
   assign idx_end = (idx == IW'(WIN - 1));
   assign ch_end  = (ch == CHW'(NCH - 1));
   assign pop     = (take && too_old) || ((st == RS_STREAM) && idx_end && ch_end);
   assign raddr   = base + AW'(idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= RS_IDLE;
         idx     <= '0;
         ch      <= '0;
         base    <= '0;
         code_r  <= '0;
         o_valid <= 1'b0;
         o_ch    <= '0;
         o_last  <= 1'b0;
         o_code  <= '0;
         o_stale <= 1'b0;
      end else begin
         o_stale <= take && too_old;
         o_valid <= (st == RS_STREAM);
         o_ch    <= ch;
         o_last  <= (st == RS_STREAM) && idx_end;
         o_code  <= code_r;
         case (st)
            RS_IDLE: begin
               if (take && !too_old) begin
                  st     <= RS_STREAM;
                  idx    <= '0;
                  ch     <= '0;
                  base   <= head_start[AW-1:0];
                  code_r <= head_code;
               end
            end
            RS_STREAM: begin
               if (idx_end) begin
                  idx <= '0;
                  if (ch_end) st <= RS_IDLE;
                  else        ch <= ch + 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st <= RS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/trig_window_buf.sv
// Top: sample ring, trigger queue and readout sequencer.
module trig_window_buf
   import twb_pkg::*;
#(
   parameter  int NCH        = 16,
   parameter  int SW         = 18,
   parameter  int DEPTH      = 512,
   parameter  int WIN        = 60,
   parameter  int PRE        = 22,
   parameter  int QD         = 8,
   parameter  int TCW        = 8,
   parameter  int AGEW       = 24,
   parameter  int LANE_SPLIT = 0,
   localparam int AW         = $clog2(DEPTH),
   localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int QCW        = $clog2(QD + 1),
   localparam int EW         = 1 + AGEW + TCW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [NCH*SW-1:0] smp_data,
   input  logic              trig,
   input  logic [TCW-1:0]    trig_code,
   input  logic              rd_grant,
   output logic              rd_req,
   output logic              out_valid,
   output logic [CHW-1:0]    out_chan,
   output logic [SW-1:0]     out_data,
   output logic              out_last,
   output logic [TCW-1:0]    out_code,
   output logic              trig_drop,
   output logic              stale_drop
);

   // elaboration-time parameter checks
   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (PRE >= WIN) begin : g_bad_pre
         $error("PRE must be smaller than WIN");
      end
      if (WIN > DEPTH) begin : g_bad_win
         $error("WIN must fit in the ring");
      end
      if ((1 << TCW) <= TCODE_MAX) begin : g_bad_tcw
         $error("TCW too narrow for the time code range");
      end
      if (AGEW <= AW + 1) begin : g_bad_agew
         $error("AGEW must exceed the ring address width by two or more");
      end
      if (QD < 2) begin : g_bad_qd
         $error("QD must be at least two");
      end
   endgenerate

   logic [AGEW-1:0] wr_abs;
   logic            primed, hist_now;
   logic [QCW-1:0]  pend;
   logic            q_full, q_empty, q_pop;
   logic [EW-1:0]   q_head, q_in;
   logic [AW-1:0]   raddr;
   logic [NCH*SW-1:0] rword;

   // a trigger has full pre-history once PRE samples are stored
   assign hist_now = primed || (wr_abs >= AGEW'(PRE));
   assign q_in     = {hist_now, wr_abs - AGEW'(PRE), trig_code};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_abs    <= '0;
         primed    <= 1'b0;
         trig_drop <= 1'b0;
      end else begin
         wr_abs    <= wr_abs + AGEW'(smp_valid);
         primed    <= hist_now;
         trig_drop <= trig && q_full;
      end
   end

   twb_ring #(
      .NCH(NCH), .SW(SW), .DEPTH(DEPTH), .LANE_SPLIT(LANE_SPLIT)
   ) u_ring (
      .clk(clk), .we(smp_valid), .waddr(wr_abs[AW-1:0]),
      .wdata(smp_data), .raddr(raddr), .rword(rword)
   );

   twb_tqueue #(.EW(EW), .QD(QD)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(trig), .din(q_in), .pop(q_pop),
      .head(q_head), .count(pend), .full(q_full), .empty(q_empty)
   );

   twb_reader #(
      .NCH(NCH), .WIN(WIN), .DEPTH(DEPTH), .AGEW(AGEW), .TCW(TCW)
   ) u_reader (
      .clk(clk), .rst_n(rst_n), .head_valid(!q_empty),
      .head_hist(q_head[EW-1]), .head_start(q_head[TCW +: AGEW]),
      .head_code(q_head[TCW-1:0]), .wr_abs(wr_abs), .rd_grant(rd_grant),
      .rd_req(rd_req), .pop(q_pop), .raddr(raddr), .o_valid(out_valid),
      .o_ch(out_chan), .o_last(out_last), .o_code(out_code),
      .o_stale(stale_drop)
   );

   // channel lane selection on the registered slot
   logic [SW-1:0] lane [NCH];
   generate
      for (genvar g = 0; g < NCH; g++) begin : g_lane
         assign lane[g] = rword[g*SW +: SW];
      end
   endgenerate
   assign out_data = lane[out_chan];

endmodule

// File: rtl/twb_check.sv
// Cycle-level properties of the trigger window buffer.
module twb_check #(
   parameter int NCH = 16,
   parameter int QD  = 8,
   parameter int CHW = 4,
   parameter int QCW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           trig,
   input logic           trig_drop,
   input logic           rd_req,
   input logic           rd_grant,
   input logic           out_valid,
   input logic           out_last,
   input logic           stale_drop,
   input logic [CHW-1:0] out_chan,
   input logic [QCW-1:0] pend
);

   assert_pend_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= QCW'(QD));

   assert_drop_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && pend == QCW'(QD)) |=> trig_drop);

   assert_drop_needs_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_drop |-> $past(trig));

   assert_req_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (!out_valid && pend != '0));

   assert_start_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(rd_grant, 2));

   assert_last_is_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_chan_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> (out_valid && $stable(out_chan)));

   assert_chan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last && out_chan != CHW'(NCH - 1)) |=>
         (out_valid && out_chan == $past(out_chan) + 1'b1));

   assert_stale_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stale_drop |-> !out_valid);

endmodule

bind trig_window_buf twb_check #(
   .NCH(NCH), .QD(QD), .CHW(CHW), .QCW(QCW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .trig_drop(trig_drop),
   .rd_req(rd_req), .rd_grant(rd_grant), .out_valid(out_valid),
   .out_last(out_last), .stale_drop(stale_drop), .out_chan(out_chan),
   .pend(pend)
);

// File: tb/sim_trig_window_buf.sv
module sim_trig_window_buf;

   localparam int NCH = 16;
   localparam int SW  = 18;
   localparam int WIN = 60;
   localparam int PRE = 22;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_valid = 1'b0;
   logic [NCH*SW-1:0] smp_data = '0;
   logic              trig = 1'b0;
   logic [7:0]        trig_code = '0;
   logic              rd_grant = 1'b0;
   logic              rd_req, out_valid, out_last, trig_drop, stale_drop;
   logic [3:0]        out_chan;
   logic [SW-1:0]     out_data;
   logic [7:0]        out_code;

   always #5 clk = ~clk;

   trig_window_buf u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .trig(trig), .trig_code(trig_code), .rd_grant(rd_grant),
      .rd_req(rd_req), .out_valid(out_valid), .out_chan(out_chan),
      .out_data(out_data), .out_last(out_last), .out_code(out_code),
      .trig_drop(trig_drop), .stale_drop(stale_drop)
   );

   typedef struct {bit stale; logic [SW-1:0] data; int ch; bit last; int code;} exp_t;
   typedef struct {int start; bit hist; int code;} pend_t;

   exp_t  expq[$];
   pend_t pq[$];
   int    nsamp = 0;
   int    total = 0;
   int    bad   = 0;
   bit    done  = 0;

   function automatic logic [SW-1:0] fval(input int n, input int c);
      return SW'(n * 37 + c * 1031 + 5);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // all drive tasks start and end one time unit after a rising edge
   task automatic put_samples(input int k);
      for (int i = 0; i < k; i++) begin
         for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = fval(nsamp, c);
         smp_valid = 1'b1;
         @(posedge clk); #1;
         nsamp++;
      end
      smp_valid = 1'b0;
   endtask

   task automatic fire(input int code);
      pend_t p;
      bit    exp_drop;
      exp_drop = (pq.size() == 8);
      if (!exp_drop) begin
         p.start = nsamp - PRE;
         p.hist  = (nsamp >= PRE);
         p.code  = code;
         pq.push_back(p);
      end
      trig = 1'b1;
      trig_code = 8'(code);
      @(posedge clk); #1;
      trig = 1'b0;
      chk(trig_drop == exp_drop, "R3 trig_drop after trigger", trig_drop, exp_drop);
   endtask

   task automatic serve();
      pend_t p;
      exp_t  e;
      int    age;
      chk(rd_req == 1'b1, "R5 rd_req with complete window", rd_req, 1);
      p = pq.pop_front();
      age = nsamp - p.start;
      if (!p.hist || age > 512) begin
         e.stale = 1; e.data = '0; e.ch = 0; e.last = 0; e.code = p.code;
         expq.push_back(e);
      end else begin
         for (int c = 0; c < NCH; c++)
            for (int i = 0; i < WIN; i++) begin
               e.stale = 0; e.data = fval(p.start + i, c); e.ch = c;
               e.last = (i == WIN - 1); e.code = p.code;
               expq.push_back(e);
            end
      end
      rd_grant = 1'b1;
      @(posedge clk); #1;
      rd_grant = 1'b0;
      while (expq.size() != 0) @(posedge clk);
      #1;
   endtask

   // monitor: compare produced words against the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (expq.size() == 0) chk(0, "R6 unexpected word", out_data, -1);
         else begin
            exp_t e;
            e = expq.pop_front();
            if (e.stale) chk(0, "R7 data where stale drop expected", 1, 0);
            else begin
               chk(out_data == e.data, "R1 sample value", out_data, e.data);
               chk(out_chan == 4'(e.ch), "R6 channel order", out_chan, e.ch);
               chk(out_last == e.last, "R6 last marker", out_last, e.last);
               chk(out_code == 8'(e.code), "R2 time code", out_code, e.code);
            end
         end
      end
      if (rst_n && stale_drop) begin
         if (expq.size() == 0) chk(0, "R7 unexpected stale drop", 1, 0);
         else begin
            exp_t e;
            e = expq.pop_front();
            chk(e.stale, "R7 stale drop where data expected", 1, 0);
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R9 reset state
      chk(rd_req == 0, "R9 rd_req after reset", rd_req, 0);
      chk(out_valid == 0, "R9 out_valid after reset", out_valid, 0);
      chk(trig_drop == 0, "R9 trig_drop after reset", trig_drop, 0);
      chk(stale_drop == 0, "R9 stale_drop after reset", stale_drop, 0);

      // trigger with too little history: stale on grant (R7)
      put_samples(10);
      fire(5);
      put_samples(37);
      chk(rd_req == 0, "R5 rd_req before window complete", rd_req, 0);
      put_samples(1);
      chk(rd_req == 1, "R5 rd_req once window complete", rd_req, 1);
      // no grant: nothing streamed (R5)
      repeat (5) @(posedge clk);
      #1;
      chk(out_valid == 0, "R5 no output without grant", out_valid, 0);
      chk(rd_req == 1, "R5 request held without grant", rd_req, 1);
      serve();

      // normal window (R6, R2)
      put_samples(52);
      fire(14);
      put_samples(37);
      chk(rd_req == 0, "R5 rd_req one sample short", rd_req, 0);
      put_samples(1);
      serve();

      // three triggers in order, codes at range ends (R4, R2)
      fire(0);
      put_samples(3);
      fire(143);
      put_samples(5);
      fire(77);
      put_samples(60);
      serve();
      serve();
      serve();
      chk(rd_req == 0, "R4 queue drained", rd_req, 0);

      // nine triggers: ninth dropped (R3)
      for (int k = 0; k < 9; k++) begin
         fire(k * 10);
         put_samples(1);
      end
      put_samples(60);
      for (int k = 0; k < 8; k++) serve();
      chk(rd_req == 0, "R3 dropped trigger never served", rd_req, 0);
      repeat (4) @(posedge clk);
      #1;
      chk(out_valid == 0, "R3 no output after drop", out_valid, 0);

      // age exactly 512 still read, across ring wrap (R8, R1)
      fire(33);
      put_samples(490);
      serve();

      // age 513 is stale (R7)
      fire(99);
      put_samples(491);
      serve();
      chk(rd_req == 0, "R7 stale entry removed", rd_req, 0);

      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule